// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave

This block is the slave end of a two-wire serial bus for a small sensor-style register file. It runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line open-drain: `sda_oe` high means "pull low". It detects start and stop conditions. It answers to a 7-bit address whose high nibble is fixed at `1001` and whose low three bits come from pins. It acknowledges bytes and keeps a two-bit register pointer.

The first byte a master writes after the address selects the target register. Any further bytes in that write are data for that register. A write that carries only the pointer byte prepares a later read. A repeated start can then switch the transfer into a read.

The register map holds four registers:
- pointer 0: a 16-bit read-only sample taken from the `sense_value` input;
- pointer 1: an 8-bit configuration register;
- pointer 2: a 16-bit hysteresis limit;
- pointer 3: a 16-bit over-limit threshold.

If the data line stays unchanged for longer than a parameter-set number of clock cycles during a transfer, the block releases the bus and waits for a start.

Top module: `i2c_sensor_regs`

## Requirements
- R1: After a start, the block shifts in seven address bits MSB first, then the R/W bit. When the address equals {1001, addr_pins}, it pulls SDA low for the ninth clock. On any other address it does not pull SDA low at all until the next start.
- R2: The address pins are resynchronised continuously, so a new pin value sets the address matched in the next transfer.
- R3: In a write transfer, the first byte after the address sets the pointer from its low two bits (0 sample, 1 configuration, 2 hysteresis, 3 over-limit). A later read transfer returns the register that this pointer selects.
- R4: Writing one data byte with pointer 1 replaces `cfg_out` with that byte.
- R5: Writes to pointers 2 and 3 take two bytes, MSB byte first. The register (`hyst_out` or `limit_out`) changes only when the second byte arrives. A single byte leaves it unchanged.
- R6: Writes with pointer 0 change nothing. A read with pointer 0 returns `sense_value`, high byte first.
- R7: A read of a 16-bit register returns the high byte, then the low byte. A read of pointer 1 returns the configuration byte for every byte requested. The master's ACK continues the read. A NACK ends it, and SDA stays released.
- R8: The block acknowledges every byte that the master writes to the matched address.
- R9: A start seen in any state, including a repeated start or one in the middle of a byte, aborts the current activity and begins a new address phase.
- R10: Suppose the synchronised SDA does not change for TIMEOUT_CYCLES clock cycles while a transfer is in progress. The block then releases SDA and ignores the bus until the next start.
- R11: Reset gives `sda_oe` = 0, `cfg_out` = 0x00, `hyst_out` = 0x4B00 and `limit_out` = 0x5000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| addr_pins | input | 3 | Low three bits of the slave address |
| sense_value | input | 16 | Sample returned by the read-only register |
| cfg_out | output | 8 | Configuration register |
| hyst_out | output | 16 | Hysteresis limit register |
| limit_out | output | 16 | Over-limit threshold register |

## Verification
Errors in the bit counter or the state machine show up on the bus within one byte time. They appear as a missing or misplaced acknowledge, or as read data shifted by a bit. The scoreboard catches them at the first wrong byte.

A wrong pointer or a wrong byte-index state shows only on a later transfer. It appears as the wrong register value on the outputs, or in a read-back. So each write is followed by a read of the same register.

A stuck idle counter shows only after the full timeout window. A test therefore parks a read with the slave holding SDA low and waits past the limit.

// File: rtl/i2c_sensor_regs.sv
module i2c_sensor_regs #(
  parameter int          TIMEOUT_CYCLES = 5_625_000,
  parameter logic [3:0]  ADDR_HI        = 4'b1001,
  parameter logic [15:0] HYST_RST       = 16'h4B00,
  parameter logic [15:0] LIMIT_RST      = 16'h5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic [2:0]  addr_pins,
  input  logic [15:0] sense_value,
  output logic [7:0]  cfg_out,
  output logic [15:0] hyst_out,
  output logic [15:0] limit_out
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK} st_t;

  st_t         st;
  logic [2:0]  scl_p, sda_p, pin_a, pin_b;
  logic [3:0]  bits;
  logic [7:0]  sh, msb_hold, lo_hold;
  logic [1:0]  ptr, widx;
  logic        rw, rd_half, nack;
  logic [TW-1:0] idle_cnt;
  logic [15:0] sel_reg;
  logic [7:0]  next_rd;

  wire scl_q = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_q = sda_p[1];
  wire sda_d = sda_p[2];

  wire start_det   = scl_q & scl_d & sda_d & ~sda_q;
  wire stop_det    = scl_q & scl_d & ~sda_d & sda_q;
  wire scl_rise    = scl_q & ~scl_d;
  wire scl_fall    = ~scl_q & scl_d;
  wire timeout_hit = (st != S_IDLE) && (idle_cnt == TW'(TIMEOUT_CYCLES - 1));

  always_comb begin
    case (ptr)
      2'd0:    sel_reg = sense_value;
      2'd1:    sel_reg = {cfg_out, cfg_out};
      2'd2:    sel_reg = hyst_out;
      default: sel_reg = limit_out;
    endcase
  end

  assign next_rd = (ptr == 2'd1) ? cfg_out : (rd_half ? lo_hold : sel_reg[15:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
      pin_a <= '0;
      pin_b <= '0;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
      pin_a <= addr_pins;
      pin_b <= pin_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (st == S_IDLE || sda_q != sda_d || timeout_hit)
      idle_cnt <= '0;
    else
      idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sda_oe <= 1'b0;
      bits <= '0;
      sh <= '0;
      msb_hold <= '0;
      lo_hold <= '0;
      ptr <= '0;
      widx <= '0;
      rw <= 1'b0;
      rd_half <= 1'b0;
      nack <= 1'b0;
      cfg_out <= '0;
      hyst_out <= HYST_RST;
      limit_out <= LIMIT_RST;
    end else if (start_det) begin
      st <= S_ADDR;
      sda_oe <= 1'b0;
      bits <= '0;
      widx <= '0;
      rd_half <= 1'b0;
    end else if (stop_det || timeout_hit) begin
      st <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR: begin
          if (scl_rise) begin
            sh <= {sh[6:0], sda_q};
            bits <= bits + 1'b1;
          end else if (scl_fall && bits == 4'd8) begin
            if (sh[7:1] == {ADDR_HI, pin_b}) begin
              sda_oe <= 1'b1;
              rw <= sh[0];
              st <= S_AACK;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          bits <= '0;
          if (rw) begin
            sh <= next_rd;
            sda_oe <= ~next_rd[7];
            if (!rd_half) lo_hold <= sel_reg[7:0];
            rd_half <= ~rd_half;
            st <= S_RBYTE;
          end else begin
            sda_oe <= 1'b0;
            st <= S_WBYTE;
          end
        end
        S_WBYTE: begin
          if (scl_rise) begin
            sh <= {sh[6:0], sda_q};
            bits <= bits + 1'b1;
          end else if (scl_fall && bits == 4'd8) begin
            sda_oe <= 1'b1;
            st <= S_WACK;
            if (widx != 2'd3) widx <= widx + 1'b1;
            case (widx)
              2'd0: ptr <= sh[1:0];
              2'd1: begin
                if (ptr == 2'd1) cfg_out <= sh;
                msb_hold <= sh;
              end
              2'd2: begin
                if (ptr == 2'd2) hyst_out <= {msb_hold, sh};
                if (ptr == 2'd3) limit_out <= {msb_hold, sh};
              end
              default: ;
            endcase
          end
        end
        S_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          bits <= '0;
          st <= S_WBYTE;
        end
        S_RBYTE: begin
          if (scl_rise) begin
            bits <= bits + 1'b1;
          end else if (scl_fall) begin
            if (bits == 4'd8) begin
              sda_oe <= 1'b0;
              st <= S_RACK;
            end else begin
              sda_oe <= ~sh[6];
              sh <= {sh[6:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            nack <= sda_q;
          end else if (scl_fall) begin
            if (nack) begin
              st <= S_IDLE;
            end else begin
              bits <= '0;
              sh <= next_rd;
              sda_oe <= ~next_rd[7];
              if (!rd_half) lo_hold <= sel_reg[7:0];
              rd_half <= ~rd_half;
              st <= S_RBYTE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_sensor_regs_chk.sv
module i2c_sensor_regs_chk #(
  parameter int LIM = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_q,
  input logic        scl_fall,
  input logic        start_det,
  input logic        sda_oe,
  input logic [2:0]  st,
  input logic [31:0] idle_cnt,
  input logic [7:0]  cfg_out,
  input logic [15:0] hyst_out,
  input logic [15:0] limit_out
);
  // R1
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  // R10
  idle_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < 32'(LIM));

  // R9
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == 3'd1 && !sda_oe));

  // R4
  cfg_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> $past(scl_fall));

  // R5
  hyst_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hyst_out) |-> $past(scl_fall));

  // R5
  limit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(limit_out) |-> $past(scl_fall));
endmodule

bind i2c_sensor_regs i2c_sensor_regs_chk #(.LIM(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .scl_fall(scl_fall),
  .start_det(start_det), .sda_oe(sda_oe), .st(st),
  .idle_cnt(32'(idle_cnt)), .cfg_out(cfg_out), .hyst_out(hyst_out),
  .limit_out(limit_out)
);

// File: tb/i2c_sensor_regs_tb.sv
module i2c_sensor_regs_tb;
  localparam int HP = 20;
  localparam int TO = 3000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  pins  = 3'b010;
  logic [15:0] sense = 16'hC3A0;
  logic        sda_oe;
  logic [7:0]  cfg;
  logic [15:0] hyst, lim;
  wire         sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, oe_cnt = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got, m_e;
  string      m_t;
  event       got_ev;
  bit         ack;

  i2c_sensor_regs #(.TIMEOUT_CYCLES(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_pins(pins), .sense_value(sense), .cfg_out(cfg), .hyst_out(hyst), .limit_out(lim)
  );

  always @(negedge clk) if (sda_oe) oe_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", 32'(got), 0);
    else begin
      m_e = exp_q.pop_front();
      m_t = tag_q.pop_front();
      chk(got == m_e, m_t, 32'(got), 32'(m_e));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HP);
      scl_m = 1'b1; tick(HP);
      scl_m = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP/2);
    a = !sda_bus; tick(HP/2);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input bit mack);
    logic [7:0] v;
    v = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      scl_m = 1'b1; tick(HP/2);
      v = {v[6:0], sda_bus}; tick(HP/2);
      scl_m = 1'b0; tick(4);
    end
    got = v;
    -> got_ev;
    sda_m = !mack; tick(HP);
    scl_m = 1'b1; tick(HP);
    scl_m = 1'b0; tick(4);
    sda_m = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input int n, input logic [7:0] b0, input logic [7:0] b1,
                    input logic [7:0] b2, input string tag);
    logic [7:0] bs[3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    bstart();
    send_byte({a, 1'b0}, ack);
    chk(ack, {tag, " R1 address ack"}, 32'(ack), 1);
    for (int k = 0; k < n; k++) begin
      send_byte(bs[k], ack);
      chk(ack, {tag, " R8 data ack"}, 32'(ack), 1);
    end
    bstop();
  endtask

  task automatic rd(input logic [6:0] a, input int n, input string tag);
    bstart();
    send_byte({a, 1'b1}, ack);
    chk(ack, {tag, " R1 read address ack"}, 32'(ack), 1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1);
    tick(8);
    chk(!sda_oe, {tag, " R7 released after nack"}, 32'(sda_oe), 0);
    bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R11 sda_oe", 32'(sda_oe), 0);
    chk(cfg == 8'h00, "R11 cfg", 32'(cfg), 32'h00);
    chk(hyst == 16'h4B00, "R11 hyst", 32'(hyst), 32'h4B00);
    chk(lim == 16'h5000, "R11 limit", 32'(lim), 32'h5000);

    // R1 mismatch: no ack and no drive for the following byte
    bstart();
    oe_cnt = 0;
    send_byte({7'h4B, 1'b0}, ack);
    chk(!ack, "R1 foreign address not acked", 32'(ack), 0);
    send_byte(8'h00, ack);
    chk(oe_cnt == 0, "R1 bus untouched after mismatch", 32'(oe_cnt), 0);
    bstop();

    wr(7'h4A, 2, 8'h01, 8'hA5, 8'h00, "R4");
    chk(cfg == 8'hA5, "R4 cfg write", 32'(cfg), 32'hA5);

    wr(7'h4A, 2, 8'h02, 8'h12, 8'h00, "R5");
    chk(hyst == 16'h4B00, "R5 single byte leaves hyst", 32'(hyst), 32'h4B00);
    wr(7'h4A, 3, 8'h02, 8'h12, 8'h34, "R5");
    chk(hyst == 16'h1234, "R5 hyst two-byte write", 32'(hyst), 32'h1234);

    wr(7'h4A, 1, 8'h02, 8'h00, 8'h00, "R3");
    expect_byte(8'h12, "R3 pointer read hyst msb");
    expect_byte(8'h34, "R3 pointer read hyst lsb");
    rd(7'h4A, 2, "R3");

    wr(7'h4A, 3, 8'h00, 8'h55, 8'h66, "R6");
    wr(7'h4A, 1, 8'h00, 8'h00, 8'h00, "R6");
    expect_byte(8'hC3, "R6 sample msb");
    expect_byte(8'hA0, "R6 sample lsb");
    rd(7'h4A, 2, "R6");

    wr(7'h4A, 1, 8'h01, 8'h00, 8'h00, "R7");
    expect_byte(8'hA5, "R7 cfg byte 1");
    expect_byte(8'hA5, "R7 cfg byte 2");
    rd(7'h4A, 2, "R7");

    // R9 repeated start switches pointer write into a read
    bstart();
    send_byte({7'h4A, 1'b0}, ack);
    send_byte(8'h03, ack);
    expect_byte(8'h50, "R9 limit msb after repeated start");
    expect_byte(8'h00, "R9 limit lsb after repeated start");
    rd(7'h4A, 2, "R9");

    // R9 start in the middle of a byte aborts it
    bstart();
    send_byte({7'h4A, 1'b0}, ack);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1; tick(HP);
      scl_m = 1'b1; tick(HP);
      scl_m = 1'b0; tick(4);
    end
    wr(7'h4A, 2, 8'h01, 8'h3C, 8'h00, "R9");
    chk(cfg == 8'h3C, "R9 write after mid-byte restart", 32'(cfg), 32'h3C);

    pins = 3'b111;
    tick(10);
    wr(7'h4F, 2, 8'h01, 8'h77, 8'h00, "R2");
    chk(cfg == 8'h77, "R2 new pin address write", 32'(cfg), 32'h77);
    bstart();
    send_byte({7'h4A, 1'b0}, ack);
    chk(!ack, "R2 old address no longer acked", 32'(ack), 0);
    bstop();

    // R10 timeout while the slave holds SDA low
    wr(7'h4F, 1, 8'h03, 8'h00, 8'h00, "R10");
    bstart();
    send_byte({7'h4F, 1'b1}, ack);
    tick(8);
    chk(sda_oe == 1'b1, "R10 slave driving before timeout", 32'(sda_oe), 1);
    tick(TO + 50);
    chk(sda_oe == 1'b0, "R10 released after timeout", 32'(sda_oe), 0);
    wr(7'h4F, 2, 8'h01, 8'h21, 8'h00, "R10");
    chk(cfg == 8'h21, "R10 recovers after timeout", 32'(cfg), 32'h21);

    tick(20);
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule